// File: doc/BRIEF.md
# Reversible BCD Decade Counter

This block is a single decimal digit held as a four-bit 8421 code. On each rising clock edge, while the active-low enable is asserted, the digit steps up or down by one. The direction input selects which way it steps. The digit wraps from 9 to 0 when stepping up and from 0 to 9 when stepping down.

An active-low load input copies a four-bit data word into the digit at once, without waiting for the clock. That makes the block usable as a programmable divider. A synchronous active-high reset clears the digit.

Two combinational flags support chaining digits into a longer decimal counter:
- `tc` marks the end of the range for the current direction.
- `rc_n` is a low pulse, limited to the low half of the clock, that a following digit can use as its clock.

Top module: `bcd_updown_counter`

## Requirements
- R1: With `load_n` HIGH, `rst` LOW, `cnt_en_n` LOW and `dir_up` = 1, each rising clock edge moves `q` from n to n+1 for n in 0..8, and from 9 to 0.
- R2: With `load_n` HIGH, `rst` LOW, `cnt_en_n` LOW and `dir_up` = 0, each rising clock edge moves `q` from n to n-1 for n in 1..9, and from 0 to 9.
- R3: With `cnt_en_n` HIGH, `q` keeps its value across rising clock edges whatever `dir_up` is.
- R4: While `load_n` is LOW, `q` equals `data_in`. The copy takes effect as soon as `load_n` falls, in either clock phase, and clock edges, enable, direction and reset have no effect until `load_n` returns HIGH.
- R5: With `load_n` HIGH, `rst` HIGH at a rising clock edge sets `q` to 0.
- R6: The codes 10 to 15, reachable only by a load, recover on a counting edge. Stepping up from any of them gives 0. Stepping down from any of them gives the code minus one, so that 10 steps down to 9.
- R7: `tc` is 1 exactly when (`dir_up` = 1 and `q` = 9) or (`dir_up` = 0 and `q` = 0). It follows a change of `dir_up` or `q` without waiting for a clock edge.
- R8: `rc_n` is 0 only while `clk` is LOW, `cnt_en_n` is LOW and `tc` is 1. It is 1 at all other times, so it rises on the rising clock edge that ends such a low phase.
- R9: When a second counter is clocked by the first counter's `rc_n`, with its own enable LOW, the second counter steps on the same rising edge on which the first counter wraps. The two counters together then count in decimal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the digit changes on its rising edge |
| rst | input | 1 | Synchronous reset, active HIGH, clears the digit |
| load_n | input | 1 | Asynchronous load, active LOW, copies `data_in` into the digit |
| cnt_en_n | input | 1 | Count enable, active LOW |
| dir_up | input | 1 | Direction: 1 steps up, 0 steps down |
| data_in | input | 4 | Value taken by an asynchronous load |
| q | output | 4 | Current digit, 8421 code |
| tc | output | 1 | End-of-range flag for the current direction, active HIGH |
| rc_n | output | 1 | Cascade clock pulse, active LOW, only during the low clock phase |

## Verification
The hardest situation to reach from the ports is the cascade boundary. There, the first digit's `rc_n` rising edge must coincide with its own wrap so that the second digit advances in the same cycle. The bench builds a real two-digit chain, with the second instance clocked from `rc_n` of the first. It preloads both digits through a shared load pulse so that a wrap arrives a few edges later, in both directions. Illegal codes are reached only through the load path, and the bench loads them mid-period before letting the digit count.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    localparam digit_t DIGIT_LOW  = digit_t'(0);
    localparam digit_t DIGIT_HIGH = digit_t'(9);

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef struct packed {
        digit_t value;
        logic   at_edge;
    } step_t;

    function automatic digit_t step_up(input digit_t cur);
        if (cur >= DIGIT_HIGH) begin
            return DIGIT_LOW;
        end
        return cur + digit_t'(1);
    endfunction

    function automatic digit_t step_down(input digit_t cur);
        if (cur == DIGIT_LOW) begin
            return DIGIT_HIGH;
        end
        return cur - digit_t'(1);
    endfunction

    function automatic logic range_end(input digit_t cur, input dir_e dir);
        return (dir == DIR_UP) ? (cur == DIGIT_HIGH) : (cur == DIGIT_LOW);
    endfunction

endpackage

// File: rtl/bcd_step_logic.sv
module bcd_step_logic
    import bcd_ctr_pkg::*;
(
    input  digit_t cur,
    input  dir_e   dir,
    output step_t  nxt
);

    always_comb begin
        nxt.at_edge = range_end(cur, dir);
        if (dir == DIR_UP) begin
            nxt.value = step_up(cur);
        end else begin
            nxt.value = step_down(cur);
        end
    end

endmodule

// File: rtl/bcd_digit_reg.sv
module bcd_digit_reg
    import bcd_ctr_pkg::*;
#(
    parameter digit_t RST_DIGIT = DIGIT_LOW
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load_n,
    input  digit_t load_val,
    input  logic   advance,
    input  digit_t next_val,
    output digit_t cur
);

    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) begin
            cur <= load_val;
        end else if (rst) begin
            cur <= RST_DIGIT;
        end else if (advance) begin
            cur <= next_val;
        end
    end

endmodule

// File: rtl/bcd_term_decode.sv
module bcd_term_decode
    import bcd_ctr_pkg::*;
(
    input  logic clk,
    input  logic cnt_en_n,
    input  logic at_edge,
    output logic tc,
    output logic rc_n
);

    always_comb begin
        tc   = at_edge;
        rc_n = ~(~cnt_en_n & at_edge & ~clk);
    end

endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
    import bcd_ctr_pkg::*;
#(
    parameter logic [3:0] RST_DIGIT = 4'd0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_n,
    input  logic       cnt_en_n,
    input  logic       dir_up,
    input  logic [3:0] data_in,
    output logic [3:0] q,
    output logic       tc,
    output logic       rc_n
);

    digit_t cur_digit;
    step_t  step;
    dir_e   dir;

    assign dir = dir_e'(dir_up);

    bcd_step_logic u_step (
        .cur (cur_digit),
        .dir (dir),
        .nxt (step)
    );

    bcd_digit_reg #(
        .RST_DIGIT (digit_t'(RST_DIGIT))
    ) u_reg (
        .clk      (clk),
        .rst      (rst),
        .load_n   (load_n),
        .load_val (digit_t'(data_in)),
        .advance  (~cnt_en_n),
        .next_val (step.value),
        .cur      (cur_digit)
    );

    bcd_term_decode u_term (
        .clk      (clk),
        .cnt_en_n (cnt_en_n),
        .at_edge  (step.at_edge),
        .tc       (tc),
        .rc_n     (rc_n)
    );

    assign q = cur_digit;

endmodule

// File: rtl/bcd_updown_checker.sv
module bcd_updown_checker (
    input logic       clk,
    input logic       rst,
    input logic       load_n,
    input logic       cnt_en_n,
    input logic       dir_up,
    input logic [3:0] data_in,
    input logic [3:0] q,
    input logic       tc,
    input logic       rc_n
);

    // Set by any load since the last rising edge, so a step check can excuse it.
    logic ld_seen;
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) ld_seen <= 1'b1;
        else         ld_seen <= 1'b0;
    end

    // R1
    a_r1_up_step: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && dir_up && q <= 4'd9)
        |=> (ld_seen || q == (($past(q) == 4'd9) ? 4'd0 : $past(q) + 4'd1)));

    // R2
    a_r2_down_step: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && !dir_up && q <= 4'd9)
        |=> (ld_seen || q == (($past(q) == 4'd0) ? 4'd9 : $past(q) - 4'd1)));

    // R3
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (load_n && cnt_en_n) |=> (ld_seen || $stable(q)));

    // R4
    a_r4_load_copy: assert property (@(posedge clk) disable iff (rst)
        !load_n |-> (q == data_in));

    // R5
    a_r5_reset_clear: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && load_n && $past(load_n) && !ld_seen) |-> (q == 4'd0));

    // R6
    a_r6_illegal_up: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && dir_up && q > 4'd9) |=> (ld_seen || q == 4'd0));

    a_r6_illegal_down: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && !dir_up && q > 4'd9) |=> (ld_seen || q == $past(q) - 4'd1));

    // R7
    a_r7_tc_ends: assert property (@(posedge clk) disable iff (rst)
        tc |-> (q == 4'd9 || q == 4'd0));

    // R8
    a_r8_rc_low_phase: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en_n && tc) |-> !rc_n);

    a_r8_rc_high_phase: assert property (@(negedge clk) disable iff (rst)
        rc_n);

endmodule

bind bcd_updown_counter bcd_updown_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .load_n   (load_n),
    .cnt_en_n (cnt_en_n),
    .dir_up   (dir_up),
    .data_in  (data_in),
    .q        (q),
    .tc       (tc),
    .rc_n     (rc_n)
);

// File: tb/bcd_updown_counter_tb_top.sv
module bcd_updown_counter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst;
    logic       load_n;
    logic       cnt_en_n;
    logic       dir_up;
    logic [3:0] data_in;
    logic [3:0] hi_data;
    logic [3:0] q, hi_q;
    logic       tc, hi_tc;
    logic       rc_n, hi_rc_n;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_updown_counter dut_i (
        .clk (clk), .rst (rst), .load_n (load_n), .cnt_en_n (cnt_en_n),
        .dir_up (dir_up), .data_in (data_in), .q (q), .tc (tc), .rc_n (rc_n)
    );

    // Upper digit of a two-digit chain, clocked by the lower digit's cascade pulse.
    bcd_updown_counter hi_i (
        .clk (rc_n), .rst (rst), .load_n (load_n), .cnt_en_n (1'b0),
        .dir_up (dir_up), .data_in (hi_data), .q (hi_q), .tc (hi_tc), .rc_n (hi_rc_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic load_val(input int v);
        data_in = 4'(v);
        load_n = 1'b0;
        #1;
        load_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        chk("R5 reset q", int'(q), 0);
        chk("R7 reset tc", int'(tc), 0);
        chk("R8 reset rc_n", int'(rc_n), 1);
    endtask

    task automatic t_up_cycle();
        cnt_en_n = 1'b0; dir_up = 1'b1;
        load_val(0);
        for (int i = 1; i <= 10; i++) begin
            tick();
            chk("R1 up step", int'(q), i % 10);
            chk("R7 tc up", int'(tc), ((i % 10) == 9) ? 1 : 0);
        end
    endtask

    task automatic t_down_cycle();
        cnt_en_n = 1'b0; dir_up = 1'b0;
        load_val(0);
        for (int i = 1; i <= 10; i++) begin
            tick();
            chk("R2 down step", int'(q), (10 - i) % 10);
            chk("R7 tc down", int'(tc), (((10 - i) % 10) == 0) ? 1 : 0);
        end
    endtask

    task automatic t_hold();
        cnt_en_n = 1'b1; dir_up = 1'b1;
        load_val(4);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R3 hold up", int'(q), 4);
        end
        dir_up = 1'b0;
        tick();
        chk("R3 hold down", int'(q), 4);
    endtask

    task automatic t_async_load();
        cnt_en_n = 1'b0; dir_up = 1'b1;
        load_val(2);
        tick();
        chk("R1 before load", int'(q), 3);
        #1;
        data_in = 4'd6;
        load_n = 1'b0;
        #1;
        chk("R4 mid-period copy", int'(q), 6);
        rst = 1'b1;
        tick();
        chk("R4 overrides count and reset", int'(q), 6);
        rst = 1'b0;
        load_n = 1'b1;
        tick();
        chk("R4 count resumes", int'(q), 7);
        @(negedge clk);
        #1;
        data_in = 4'd1;
        load_n = 1'b0;
        #1;
        chk("R4 low-phase copy", int'(q), 1);
        load_n = 1'b1;
        tick();
        chk("R1 after low-phase load", int'(q), 2);
    endtask

    task automatic t_illegal();
        cnt_en_n = 1'b0; dir_up = 1'b1;
        load_val(12);
        chk("R7 tc illegal", int'(tc), 0);
        tick();
        chk("R6 up from 12", int'(q), 0);
        dir_up = 1'b0;
        load_val(15);
        tick();
        chk("R6 down from 15", int'(q), 14);
        tick();
        chk("R6 down from 14", int'(q), 13);
        load_val(10);
        tick();
        chk("R6 down from 10", int'(q), 9);
    endtask

    task automatic t_tc_dir();
        cnt_en_n = 1'b1; dir_up = 1'b1;
        load_val(9);
        #1;
        chk("R7 tc at 9 up", int'(tc), 1);
        dir_up = 1'b0;
        #1;
        chk("R7 tc at 9 down", int'(tc), 0);
        load_val(0);
        chk("R7 tc at 0 down", int'(tc), 1);
        dir_up = 1'b1;
        #1;
        chk("R7 tc at 0 up", int'(tc), 0);
        tick();
        load_val(9);
        cnt_en_n = 1'b0; dir_up = 1'b0;
        tick();
        chk("R2 reverse at 9", int'(q), 8);
        dir_up = 1'b1;
        load_val(0);
        tick();
        chk("R1 reverse at 0", int'(q), 1);
    endtask

    task automatic t_rc();
        cnt_en_n = 1'b1; dir_up = 1'b1;
        load_val(9);
        @(negedge clk);
        #1;
        chk("R8 rc_n high with enable off", int'(rc_n), 1);
        cnt_en_n = 1'b0;
        #1;
        chk("R8 rc_n low in low phase", int'(rc_n), 0);
        @(posedge clk);
        #1;
        chk("R8 rc_n high at rise", int'(rc_n), 1);
        chk("R1 wrap with rc", int'(q), 0);
        @(negedge clk);
        #1;
        chk("R8 rc_n high when tc low", int'(rc_n), 1);
    endtask

    task automatic t_cascade();
        tick();
        cnt_en_n = 1'b0; dir_up = 1'b1;
        hi_data = 4'd3;
        load_val(7);
        for (int i = 1; i <= 13; i++) begin
            tick();
            chk("R9 cascade low digit", int'(q), (7 + i) % 10);
            chk("R9 cascade high digit", int'(hi_q), 3 + (7 + i) / 10);
        end
        tick();
        dir_up = 1'b0;
        hi_data = 4'd5;
        load_val(1);
        tick();
        chk("R9 down low digit", int'(q), 0);
        chk("R9 down high holds", int'(hi_q), 5);
        tick();
        chk("R9 down low wraps", int'(q), 9);
        chk("R9 down high borrows", int'(hi_q), 4);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; load_n = 1'b1; cnt_en_n = 1'b1; dir_up = 1'b1;
        data_in = 4'd5; hi_data = 4'd0;
        #1;
        load_n = 1'b0;
        #1;
        load_n = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        t_reset();
        t_up_cycle();
        t_down_cycle();
        t_hold();
        t_async_load();
        t_illegal();
        t_tc_dir();
        t_rc();
        t_cascade();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule